// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. A system clock drives all of its logic. A one-cycle enable (`tick`) pulses at 8 or 16 times the bit rate, and the block uses it to time the search for a start bit and the sampling of each bit. The following are set by configuration inputs: the character length, the parity treatment, the bit order and the oversampling ratio. The host changes these only while the line is idle.

A received character appears on `rx_data` with `rx_valid` raised. `rx_valid` stays high until the host pulses `rd_ack`. The block raises sticky flags for four conditions: a parity mismatch, a low stop bit, a character lost to overrun, and a break on the line. The flags stay set until `clr_status` is pulsed. In multidrop mode, the bit in the parity position marks the character as an address or as data. After a character has been received, an idle timer measures how long the line stays quiet, which lets the host end frames of variable length.

Top module: `serial_frame_rx`

## Requirements
- R1: While `rst_n` is low, and until the first character or error after reset, `rx_valid`, `rx_addr`, all error flags, `brk_det` and `rx_timeout` are 0.
- R2: The block notes a low sample on a tick as a possible start bit. It accepts the start bit only if the line still votes low at mid-bit. A low pulse shorter than half a bit produces no character.
- R3: The character length is 5 + `cfg_len` bits for codes 0 to 4; codes 5 to 7 give 9 bits. Bits above the length read 0. If `cfg_msb_first` is 1, the first received data bit lands in the highest bit of the character; if it is 0, it lands in bit 0.
- R4: If `cfg_os8` is 1, a bit lasts 8 ticks; if it is 0, a bit lasts 16 ticks. Each bit value is the majority of the samples taken N/2-1, N/2 and N/2+1 ticks after the start of the bit. A single flipped sample at the bit centre therefore does not change the bit.
- R5: `cfg_par` selects the parity treatment: 0 = no parity bit, 1 = even, 2 = odd, 3 = parity bit must be 1, 4 = parity bit must be 0, 5 = multidrop, 6 and 7 = no parity bit. In modes 1 to 4, a mismatch sets `err_parity`.
- R6: In mode 5, the received parity-position bit is copied to `rx_addr` when the character is loaded (1 = address). In every other mode, a loaded character clears `rx_addr`. `rx_addr` changes only when a character is loaded.
- R7: If the stop bit is sampled low and the frame is not a break, the block sets `err_frame` and still delivers the character.
- R8: If a character completes while `rx_valid` is high and `rd_ack` is not given, the block sets `err_overrun`, keeps `rx_data` and `rx_addr` unchanged, and discards the new character.
- R9: If `rd_ack` arrives in the same cycle that a character completes, the block loads the new character, leaves `rx_valid` high and does not flag an overrun.
- R10: A frame whose start, data, parity and stop positions are all sampled 0 sets `brk_det` and delivers no character. The block then waits for the line to go high before it hunts for a new start bit.
- R11: After a character completes, `rx_timeout` rises once the line has been idle for `cfg_timeout` bit periods. A value of 0 disables the timer. Each completed character restarts the count.
- R12: Pulsing `to_restart` clears `rx_timeout` and disarms the timer until the next character completes.
- R13: The error flags and `brk_det` stay set until `clr_status` is pulsed, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling enable, one clock wide |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len | input | 3 | Character length code |
| cfg_par | input | 3 | Parity treatment code |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| cfg_os8 | input | 1 | 1 = 8 ticks per bit, 0 = 16 |
| cfg_timeout | input | TO_W | Idle limit in bit periods, 0 = off |
| rd_ack | input | 1 | Host has read the character |
| clr_status | input | 1 | Clears the sticky flags |
| to_restart | input | 1 | Clears and disarms the idle timer |
| rx_data | output | MAX_BITS | Received character |
| rx_valid | output | 1 | Character waiting to be read |
| rx_addr | output | 1 | Multidrop address marker |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| brk_det | output | 1 | Sticky break detected |
| rx_timeout | output | 1 | Idle time-out reached |

## Verification
Two events can fall in the same cycle: the completion of a character at the stop-bit decision, and the host's read acknowledge. The bench first leaves one character unread. It then counts ticks through the next frame and raises `rd_ack` in exactly the cycle after the stop decision, which is the cycle in which the status register loads. The result is correct if the second character is on `rx_data`, `rx_valid` is still high and `err_overrun` is still clear. In the opposite case, where no acknowledge arrives, the bench expects the first character to be kept and the overrun flag to be set.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_DATA,
      S_PAR,
      S_STOP,
      S_BRK
   } srx_state_e;

   localparam logic [2:0] PM_NONE = 3'd0;
   localparam logic [2:0] PM_EVEN = 3'd1;
   localparam logic [2:0] PM_ODD  = 3'd2;
   localparam logic [2:0] PM_ONE  = 3'd3;
   localparam logic [2:0] PM_ZERO = 3'd4;
   localparam logic [2:0] PM_ADDR = 3'd5;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/srx_sampler.sv
module srx_sampler #(
   parameter int SYNC_STAGES = 2,
   parameter bit VOTE        = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rxd_i,
   input  logic hunt,
   input  logic os8,
   output logic line,
   output logic bit_o,
   output logic strobe
);
   import srx_pkg::*;

   localparam int CW = 4;

   logic [CW-1:0] cnt;
   logic [1:0]    hist;
   logic [CW-1:0] lim, mid;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign line = rxd_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '1;
            end else begin
               sr[0] <= rxd_i;
               for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign line = sr[SYNC_STAGES-1];
      end
   endgenerate

   assign lim = os8 ? CW'(7) : CW'(15);
   assign mid = os8 ? CW'(5) : CW'(9);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         hist <= '1;
      end else if (tick) begin
         hist <= {hist[0], line};
         if (hunt)            cnt <= CW'(1);
         else if (cnt == lim) cnt <= '0;
         else                 cnt <= cnt + CW'(1);
      end
   end

   assign strobe = tick && !hunt && (cnt == mid);

   generate
      if (VOTE) begin : g_vote
         assign bit_o = vote3(hist[1], hist[0], line);
      end else begin : g_single
         assign bit_o = hist[0];
      end
   endgenerate

endmodule

// File: rtl/srx_frame.sv
module srx_frame #(
   parameter int MAX_BITS = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                line,
   input  logic                strobe,
   input  logic                bit_i,
   input  logic [2:0]          cfg_len,
   input  logic [2:0]          cfg_par,
   input  logic                cfg_msb,
   output logic                hunt,
   output logic                idle,
   output logic                done,
   output logic                brk_p,
   output logic                ferr,
   output logic                perr,
   output logic                pbit,
   output logic [MAX_BITS-1:0] data
);
   import srx_pkg::*;

   localparam int IW = $clog2(MAX_BITS + 1);

   srx_state_e    st;
   logic [IW-1:0] idx, nbits, raw_len, pos;
   logic          any1, has_par, want;

   assign raw_len = IW'(5) + IW'(cfg_len);
   assign nbits   = (raw_len > IW'(MAX_BITS)) ? IW'(MAX_BITS) : raw_len;
   assign pos     = cfg_msb ? (nbits - IW'(1) - idx) : idx;
   assign has_par = (cfg_par != PM_NONE) && (cfg_par <= PM_ADDR);

   always_comb begin
      case (cfg_par)
         PM_EVEN: want = ^data;
         PM_ODD:  want = ~^data;
         PM_ONE:  want = 1'b1;
         default: want = 1'b0;
      endcase
   end

   assign perr = (cfg_par >= PM_EVEN) && (cfg_par <= PM_ZERO) && (pbit != want);
   assign hunt = (st == S_IDLE) || (st == S_BRK);
   assign idle = (st == S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         idx   <= '0;
         data  <= '0;
         pbit  <= 1'b0;
         any1  <= 1'b0;
         done  <= 1'b0;
         brk_p <= 1'b0;
         ferr  <= 1'b0;
      end else begin
         done  <= 1'b0;
         brk_p <= 1'b0;
         case (st)
            S_IDLE: if (tick && !line) st <= S_START;
            S_START: if (strobe) begin
               if (bit_i) begin
                  st <= S_IDLE;
               end else begin
                  st   <= S_DATA;
                  idx  <= '0;
                  data <= '0;
                  pbit <= 1'b0;
                  any1 <= 1'b0;
               end
            end
            S_DATA: if (strobe) begin
               data[pos] <= bit_i;
               any1      <= any1 | bit_i;
               idx       <= idx + IW'(1);
               if (idx == nbits - IW'(1)) st <= has_par ? S_PAR : S_STOP;
            end
            S_PAR: if (strobe) begin
               pbit <= bit_i;
               any1 <= any1 | bit_i;
               st   <= S_STOP;
            end
            S_STOP: if (strobe) begin
               if (!bit_i && !any1) begin
                  brk_p <= 1'b1;
                  st    <= S_BRK;
               end else begin
                  done <= 1'b1;
                  ferr <= !bit_i;
                  st   <= S_IDLE;
               end
            end
            S_BRK: if (tick && line) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/srx_timeout.sv
module srx_timeout #(
   parameter int TO_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            os8,
   input  logic            idle,
   input  logic            arm,
   input  logic            restart,
   input  logic [TO_W-1:0] limit,
   output logic            fire
);
   localparam int SW = 4;

   logic            armed;
   logic [SW-1:0]   sub, sub_lim;
   logic [TO_W-1:0] periods;

   assign sub_lim = os8 ? SW'(7) : SW'(15);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         sub     <= '0;
         periods <= '0;
         fire    <= 1'b0;
      end else if (restart) begin
         armed   <= 1'b0;
         sub     <= '0;
         periods <= '0;
         fire    <= 1'b0;
      end else if (arm) begin
         armed   <= 1'b1;
         sub     <= '0;
         periods <= '0;
      end else if (!idle) begin
         sub     <= '0;
         periods <= '0;
      end else if (tick && armed && (limit != '0)) begin
         if (sub == sub_lim) begin
            sub <= '0;
            if (periods + TO_W'(1) == limit) begin
               fire    <= 1'b1;
               armed   <= 1'b0;
               periods <= '0;
            end else begin
               periods <= periods + TO_W'(1);
            end
         end else begin
            sub <= sub + SW'(1);
         end
      end
   end

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
   parameter int MAX_BITS    = 9,
   parameter int TO_W        = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit VOTE        = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                rxd,
   input  logic [2:0]          cfg_len,
   input  logic [2:0]          cfg_par,
   input  logic                cfg_msb_first,
   input  logic                cfg_os8,
   input  logic [TO_W-1:0]     cfg_timeout,
   input  logic                rd_ack,
   input  logic                clr_status,
   input  logic                to_restart,
   output logic [MAX_BITS-1:0] rx_data,
   output logic                rx_valid,
   output logic                rx_addr,
   output logic                err_parity,
   output logic                err_frame,
   output logic                err_overrun,
   output logic                brk_det,
   output logic                rx_timeout
);
   import srx_pkg::*;

   generate
      if (MAX_BITS < 5 || MAX_BITS > 9) begin : g_bad_bits
         $error("serial_frame_rx: MAX_BITS must lie in 5..9");
      end
      if (TO_W < 1 || TO_W > 16) begin : g_bad_to
         $error("serial_frame_rx: TO_W must lie in 1..16");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("serial_frame_rx: SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   logic                line, bit_v, strobe, hunt, idle;
   logic                done, brk_p, ferr, perr, pbit;
   logic [MAX_BITS-1:0] fdata;

   srx_sampler #(.SYNC_STAGES(SYNC_STAGES), .VOTE(VOTE)) u_samp (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_i(rxd), .hunt(hunt),
      .os8(cfg_os8), .line(line), .bit_o(bit_v), .strobe(strobe)
   );

   srx_frame #(.MAX_BITS(MAX_BITS)) u_frm (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line(line), .strobe(strobe),
      .bit_i(bit_v), .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_msb(cfg_msb_first),
      .hunt(hunt), .idle(idle), .done(done), .brk_p(brk_p), .ferr(ferr),
      .perr(perr), .pbit(pbit), .data(fdata)
   );

   srx_timeout #(.TO_W(TO_W)) u_to (
      .clk(clk), .rst_n(rst_n), .tick(tick), .os8(cfg_os8), .idle(idle),
      .arm(done), .restart(to_restart), .limit(cfg_timeout), .fire(rx_timeout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data     <= '0;
         rx_valid    <= 1'b0;
         rx_addr     <= 1'b0;
         err_parity  <= 1'b0;
         err_frame   <= 1'b0;
         err_overrun <= 1'b0;
         brk_det     <= 1'b0;
      end else begin
         if (clr_status) begin
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
            brk_det     <= 1'b0;
         end
         if (rd_ack) rx_valid <= 1'b0;
         if (brk_p) brk_det <= 1'b1;
         if (done) begin
            if (rx_valid && !rd_ack) begin
               err_overrun <= 1'b1;
            end else begin
               rx_data  <= fdata;
               rx_valid <= 1'b1;
               rx_addr  <= (cfg_par == PM_ADDR) && pbit;
               if (perr) err_parity <= 1'b1;
               if (ferr) err_frame  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
   parameter int DW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_ack,
   input logic          clr_status,
   input logic          to_restart,
   input logic [DW-1:0] rx_data,
   input logic          rx_valid,
   input logic          rx_addr,
   input logic          err_parity,
   input logic          err_overrun,
   input logic          brk_det,
   input logic          rx_timeout
);

   // R8
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rd_ack) |=> ($stable(rx_data) && rx_valid));

   // R6
   addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_addr) |-> rx_valid);

   // R13
   parity_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_parity && !clr_status) |=> err_parity);

   // R13
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_overrun && !clr_status) |=> err_overrun);

   // R12
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      to_restart |=> !rx_timeout);

   // R10
   brk_nochar_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_det) |-> $stable(rx_data));

endmodule

bind serial_frame_rx srx_checker #(.DW(MAX_BITS)) u_chk (.*);

// File: tb/sim_serial_frame_rx.sv
module sim_serial_frame_rx;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] tcnt = 2'd0;
   logic       rxd = 1'b1;
   logic [2:0] cfg_len = 3'd3;
   logic [2:0] cfg_par = 3'd0;
   logic       cfg_msb_first = 1'b0;
   logic       cfg_os8 = 1'b0;
   logic [7:0] cfg_timeout = 8'd0;
   logic       rd_ack = 1'b0, clr_status = 1'b0, to_restart = 1'b0;
   logic [8:0] rx_data;
   logic       rx_valid, rx_addr, err_parity, err_frame, err_overrun, brk_det, rx_timeout;

   int nchk = 0, nfail = 0;
   bit m_valid = 0, m_addr = 0, m_pe = 0, m_fe = 0, m_ov = 0, m_brk = 0;
   int m_data = 0;

   serial_frame_rx u0 (.*);

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      tcnt <= (tcnt == 2'd2) ? 2'd0 : tcnt + 2'd1;
      tick <= (tcnt == 2'd2);
   end

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary;
      $display("  %0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   task automatic tick_wait;
      do @(negedge clk); while (!tick);
   endtask

   function automatic int nbits_of(input logic [2:0] c);
      return (c > 3'd4) ? 9 : 5 + int'(c);
   endfunction

   function automatic bit par_of(input logic [2:0] mode, input int d);
      case (mode)
         3'd1: return ^d[8:0];
         3'd2: return ~^d[8:0];
         3'd3: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic pulse_ack;
      @(negedge clk) rd_ack = 1'b1;
      @(negedge clk) rd_ack = 1'b0;
      m_valid = 0;
   endtask

   task automatic pulse_clr;
      @(negedge clk) clr_status = 1'b1;
      @(negedge clk) clr_status = 1'b0;
      m_pe = 0; m_fe = 0; m_ov = 0; m_brk = 0;
   endtask

   task automatic idle_ticks(input int n);
      rxd = 1'b1;
      repeat (n) tick_wait();
   endtask

   // sends one frame with the current configuration and updates the model
   task automatic send(input int d, input bit pflip, input bit stopv, input bit abit,
                       input int glitch, input bit ackdone);
      int n, nb, cnt, dec, mask;
      bit hp, pb, isbrk;
      logic fr [0:11];
      n    = cfg_os8 ? 8 : 16;
      dec  = n/2 + 3;
      nb   = nbits_of(cfg_len);
      mask = (1 << nb) - 1;
      d    = d & mask;
      hp   = (cfg_par != 3'd0) && (cfg_par <= 3'd5);
      pb   = (cfg_par == 3'd5) ? abit : (par_of(cfg_par, d) ^ pflip);
      fr[0] = 1'b0;
      for (int i = 0; i < nb; i++) fr[1+i] = cfg_msb_first ? d[nb-1-i] : d[i];
      cnt = nb + 1;
      if (hp) begin fr[cnt] = pb; cnt++; end
      for (int k = 0; k < cnt; k++) begin
         for (int t = 0; t < n; t++) begin
            rxd = (glitch == k && t == n/2) ? ~fr[k] : fr[k];
            tick_wait();
         end
      end
      rxd = stopv;
      repeat (dec) tick_wait();
      if (ackdone) begin
         @(negedge clk) rd_ack = 1'b1;
         @(negedge clk) rd_ack = 1'b0;
      end
      repeat (n - dec) tick_wait();
      isbrk = (d == 0) && (!hp || !pb) && !stopv;
      if (isbrk) begin
         m_brk = 1;
      end else if (m_valid && !ackdone) begin
         m_ov = 1;
      end else begin
         m_valid = 1;
         m_data  = d;
         m_addr  = (cfg_par == 3'd5) && abit;
         if (cfg_par >= 3'd1 && cfg_par <= 3'd4 && pflip) m_pe = 1;
         if (!stopv) m_fe = 1;
      end
   endtask

   task automatic compare_all(input string tag);
      check({"R3 rx_valid ", tag}, rx_valid, m_valid);
      if (m_valid) check({"R3 rx_data ", tag}, rx_data, m_data);
      check({"R6 rx_addr ", tag}, rx_addr, m_addr);
      check({"R5 err_parity ", tag}, err_parity, m_pe);
      check({"R7 err_frame ", tag}, err_frame, m_fe);
      check({"R8 err_overrun ", tag}, err_overrun, m_ov);
      check({"R10 brk_det ", tag}, brk_det, m_brk);
   endtask

   initial begin
      void'($urandom(32'h5eed));
      repeat (4) @(negedge clk);
      // R1: reset state
      check("R1 valid in reset", rx_valid, 0);
      check("R1 timeout in reset", rx_timeout, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      compare_all("R1 after reset");

      // R2: short low pulse is not a start bit
      cfg_os8 = 1'b0;
      rxd = 1'b0; repeat (3) tick_wait();
      idle_ticks(30);
      check("R2 short pulse ignored", rx_valid, 0);

      // R4: flipped centre sample on start bit and on a data bit
      cfg_len = 3'd3; cfg_par = 3'd0; cfg_msb_first = 1'b0;
      send(8'hA5, 0, 1, 0, 0, 0); idle_ticks(14);
      compare_all("R4 glitch start");
      pulse_ack();
      cfg_os8 = 1'b1;
      send(8'h3C, 0, 1, 0, 4, 0); idle_ticks(14);
      compare_all("R4 glitch data os8");
      check("R4 data", rx_data, 8'h3C);

      // R8: overrun keeps old data
      send(8'h11, 0, 1, 0, -1, 0); idle_ticks(14);
      check("R8 old data kept", rx_data, 8'h3C);
      check("R8 overrun flag", err_overrun, 1);
      compare_all("R8");
      pulse_clr();
      check("R13 cleared overrun", err_overrun, 0);

      // R9: ack in the completion cycle
      send(8'h5A, 0, 1, 0, -1, 1); idle_ticks(14);
      check("R9 new data", rx_data, 8'h5A);
      check("R9 no overrun", err_overrun, 0);
      check("R9 valid", rx_valid, 1);
      pulse_ack();

      // R10: break frame
      cfg_par = 3'd1;
      send(0, 0, 0, 0, -1, 0);
      idle_ticks(14);
      check("R10 break flag", brk_det, 1);
      check("R10 no char", rx_valid, 0);
      compare_all("R10");
      pulse_clr();

      // random frames
      for (int f = 0; f < 40; f++) begin
         int d;
         bit pf, sv, ab;
         cfg_len       = 3'($urandom_range(0, 4));
         cfg_par       = 3'($urandom_range(0, 5));
         cfg_msb_first = 1'($urandom_range(0, 1));
         cfg_os8       = 1'($urandom_range(0, 1));
         d  = int'($urandom_range(0, 511));
         pf = ($urandom_range(0, 5) == 0);
         sv = ($urandom_range(0, 7) != 0);
         ab = 1'($urandom_range(0, 1));
         send(d, pf, sv, ab, -1, 0);
         idle_ticks(12 + int'($urandom_range(0, 8)));
         compare_all($sformatf("random frame %0d", f));
         if ($urandom_range(0, 2) != 0) pulse_ack();
         if ($urandom_range(0, 3) == 0) pulse_clr();
      end
      pulse_ack();
      pulse_clr();

      // R11 / R12: idle time-out
      cfg_len = 3'd3; cfg_par = 3'd0; cfg_os8 = 1'b1; cfg_timeout = 8'd3;
      @(negedge clk) to_restart = 1'b1;
      @(negedge clk) to_restart = 1'b0;
      idle_ticks(40);
      check("R11 not armed before a character", rx_timeout, 0);
      send(8'h42, 0, 1, 0, -1, 0);
      idle_ticks(20);
      check("R11 timeout not yet", rx_timeout, 0);
      idle_ticks(6);
      check("R11 timeout fired", rx_timeout, 1);
      @(negedge clk) to_restart = 1'b1;
      @(negedge clk) to_restart = 1'b0;
      check("R12 restart clears", rx_timeout, 0);
      idle_ticks(60);
      check("R12 disarmed stays low", rx_timeout, 0);
      pulse_ack();

      summary();
   end
endmodule